// File: doc/BRIEF.md
# Trigger-Unit Fault and Interrupt Aggregator

This block gathers the fault conditions of a cross-triggering unit into sticky flags and turns them, along with the unit's normal events, into interrupt and DMA requests. It watches the trigger generator sub-unit's input events and outgoing triggers, the master reload strobe and the ADC command decoder. From these it raises three faults. A sequential-mode overrun means a new event came in before the trigger chosen by the previous event had fired. A reload overrun means a master reload came before every enabled trigger of the current period had fired. A command fault marks an ADC command that was not recognised.

Software reads the flags and clears each one by writing 1 to its bit through a small write port. A bit written as 0 is left as it is. One error interrupt line stays asserted while any fault flag is set and the error interrupt is enabled. Each trigger event and the master reload have their own sticky interrupt flag, gated by an enable bit. A master reload also produces a one-cycle DMA request when DMA is enabled.

Top module: `ctu_fault_agg`

## Requirements
- R1: An internal busy state is set on the edge after `ev_i` is high and cleared on the edge after any `trig_i` bit is high. When both are high in the same cycle, the event wins and busy is set.
- R2: `fault_o[0]` (sequential overrun) is set on the edge after a cycle in which `seq_mode_i`, `ev_i` and busy are all high and no `trig_i` bit is high. With `seq_mode_i` low it is never set.
- R3: `fault_o[1]` (reload overrun) is set on the edge after `mrs_i` if some bit set in `trig_en_i` has no matching `trig_i` pulse in the current period. A trigger pulse in the same cycle as `mrs_i` counts as fired.
- R4: Each `mrs_i` ends the period and clears the record of fired triggers. A trigger in the reload cycle is not carried into the next period.
- R5: `fault_o[2]` (invalid command) is set on the edge after `bad_cmd_i`.
- R6: A write with `wr_sel_i`=0 clears each `fault_o` bit whose `wr_data_i` bit is 1 and leaves the bits written 0 unchanged. A set condition in the same cycle wins over the clear.
- R7: `err_irq_o` is high exactly while `err_irq_en_i` is high and at least one `fault_o` bit is set.
- R8: Trigger `i` sets a sticky interrupt flag, and `trig_irq_o[i]` is that flag ANDed with `trig_irq_en_i[i]`. A write with `wr_sel_i`=1 and `wr_data_i[i]`=1 clears the flag.
- R9: `mrs_i` sets a sticky reload interrupt flag. `mrs_irq_o` is that flag ANDed with `mrs_irq_en_i`. The flag is cleared by a write with `wr_sel_i`=1 and `wr_data_i[N_TRIG]`=1.
- R10: `mrs_dma_o` is a one-cycle pulse on the edge after `mrs_i` when `dma_en_i` is high. It stays low otherwise.
- R11: After reset, all flags are clear, busy is clear and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 1 | Incoming event strobe to trigger generator |
| trig_i | input | N_TRIG | Outgoing trigger event strobes |
| mrs_i | input | 1 | Master reload strobe |
| seq_mode_i | input | 1 | Trigger generator in sequential mode |
| bad_cmd_i | input | 1 | Unrecognised ADC command strobe |
| trig_en_i | input | N_TRIG | Triggers expected each period |
| trig_irq_en_i | input | N_TRIG | Per-trigger interrupt enables |
| mrs_irq_en_i | input | 1 | Reload interrupt enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| dma_en_i | input | 1 | Reload DMA enable |
| wr_en_i | input | 1 | Write-one-to-clear strobe |
| wr_sel_i | input | 1 | 0: fault flags, 1: interrupt flags |
| wr_data_i | input | N_TRIG+1 | Clear mask |
| fault_o | output | 3 | Fault flags {cmd, reload, seq} |
| err_irq_o | output | 1 | Error interrupt |
| trig_irq_o | output | N_TRIG | Per-trigger interrupts |
| mrs_irq_o | output | 1 | Reload interrupt |
| mrs_dma_o | output | 1 | Reload DMA request |

## Verification
Every flag, and the DMA pulse, is registered. Each result therefore appears on the first clock edge after the stimulus cycle. The interrupt lines follow their flags with no further delay, so they are due on that same edge. The bench drives each stimulus just after a rising edge, waits for exactly one edge and samples 1 ns later, away from both edges. For the DMA pulse it also samples one edge further on to confirm the pulse has ended. The reload overrun is swept over every pair of enable mask and fired set. The sequential overrun is swept over every combination of mode, prior busy state and same-cycle trigger.

// File: rtl/ctu_flag_pkg.sv
package ctu_flag_pkg;
  localparam int unsigned FLT_SEQ = 0;
  localparam int unsigned FLT_RLD = 1;
  localparam int unsigned FLT_CMD = 2;
  localparam int unsigned NUM_FLT = 3;
  typedef enum logic {SEL_FAULT = 1'b0, SEL_IRQ = 1'b1} wr_sel_e;
endpackage

// File: rtl/seq_busy_tracker.sv
module seq_busy_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic trig_any_i,
  input  logic seq_mode_i,
  output logic busy_o,
  output logic ovr_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_q <= 1'b0;
    else if (ev_i)       busy_q <= 1'b1;  // new event wins over trigger
    else if (trig_any_i) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;
  assign ovr_o  = seq_mode_i & ev_i & busy_q & ~trig_any_i;
endmodule

// File: rtl/reload_checker.sv
module reload_checker #(
  parameter int unsigned N_TRIG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [N_TRIG-1:0] trig_en_i,
  input  logic              mrs_i,
  output logic              ovr_o
);
  logic [N_TRIG-1:0] fired_q;
  logic [N_TRIG-1:0] fired_now;

  assign fired_now = fired_q | trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fired_q <= '0;
    else if (mrs_i) fired_q <= '0;
    else            fired_q <= fired_now;
  end

  assign ovr_o = mrs_i & |(trig_en_i & ~fired_now);
endmodule

// File: rtl/w1c_flag_bank.sv
module w1c_flag_bank #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;  // set beats clear
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/ctu_fault_agg.sv
module ctu_fault_agg
  import ctu_flag_pkg::*;
#(
  parameter int unsigned N_TRIG = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              mrs_i,
  input  logic              seq_mode_i,
  input  logic              bad_cmd_i,
  input  logic [N_TRIG-1:0] trig_en_i,
  input  logic [N_TRIG-1:0] trig_irq_en_i,
  input  logic              mrs_irq_en_i,
  input  logic              err_irq_en_i,
  input  logic              dma_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [N_TRIG:0]   wr_data_i,
  output logic [2:0]        fault_o,
  output logic              err_irq_o,
  output logic [N_TRIG-1:0] trig_irq_o,
  output logic              mrs_irq_o,
  output logic              mrs_dma_o
);
  localparam int unsigned IRQ_W = N_TRIG + 1;

  logic busy, seq_ovr, rld_ovr, dma_q;
  logic [NUM_FLT-1:0] flt_set, flt_clr, flt_q;
  logic [IRQ_W-1:0]   irq_set, irq_clr, irq_q;

  seq_busy_tracker u_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev_i),
    .trig_any_i (|trig_i),
    .seq_mode_i (seq_mode_i),
    .busy_o     (busy),
    .ovr_o      (seq_ovr)
  );

  reload_checker #(.N_TRIG(N_TRIG)) u_rld (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .trig_en_i (trig_en_i),
    .mrs_i     (mrs_i),
    .ovr_o     (rld_ovr)
  );

  always_comb begin
    flt_set          = '0;
    flt_set[FLT_SEQ] = seq_ovr;
    flt_set[FLT_RLD] = rld_ovr;
    flt_set[FLT_CMD] = bad_cmd_i;
    flt_clr = (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_FAULT) ? wr_data_i[NUM_FLT-1:0] : '0;
    irq_set = {mrs_i, trig_i};
    irq_clr = (wr_en_i && wr_sel_e'(wr_sel_i) == SEL_IRQ) ? wr_data_i : '0;
  end

  w1c_flag_bank #(.WIDTH(NUM_FLT)) u_flt (
    .clk_i (clk_i), .rst_ni (rst_ni), .set_i (flt_set), .clr_i (flt_clr), .flag_o (flt_q)
  );

  w1c_flag_bank #(.WIDTH(IRQ_W)) u_irq (
    .clk_i (clk_i), .rst_ni (rst_ni), .set_i (irq_set), .clr_i (irq_clr), .flag_o (irq_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dma_q <= 1'b0;
    else         dma_q <= mrs_i & dma_en_i;
  end

  assign fault_o    = flt_q;
  assign err_irq_o  = err_irq_en_i & |flt_q;
  assign trig_irq_o = irq_q[N_TRIG-1:0] & trig_irq_en_i;
  assign mrs_irq_o  = irq_q[N_TRIG] & mrs_irq_en_i;
  assign mrs_dma_o  = dma_q;
endmodule

// File: rtl/ctu_fault_agg_chk.sv
module ctu_fault_agg_chk #(
  parameter int unsigned N_TRIG = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ev_i,
  input logic [N_TRIG-1:0] trig_i,
  input logic              mrs_i,
  input logic              seq_mode_i,
  input logic              bad_cmd_i,
  input logic              dma_en_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [N_TRIG:0]   wr_data_i,
  input logic [2:0]        fault_o,
  input logic              err_irq_o,
  input logic              mrs_dma_o,
  input logic              busy
);
  // R1
  busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) ev_i |=> busy);
  // R2
  seq_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_mode_i && ev_i && busy && trig_i == '0) |=> fault_o[0]);
  // R5
  bad_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) bad_cmd_i |=> fault_o[2]);
  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((fault_o & $past(fault_o)) == $past(fault_o)));
  // R6
  cmd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && wr_data_i[2] && !bad_cmd_i) |=> !fault_o[2]);
  // R7
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) err_irq_o |-> fault_o != 3'b000);
  // R10
  dma_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (mrs_i && dma_en_i) |=> mrs_dma_o);
  // R10
  dma_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) mrs_dma_o && !mrs_i |=> !mrs_dma_o);
endmodule

bind ctu_fault_agg ctu_fault_agg_chk #(.N_TRIG(N_TRIG)) i_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .ev_i (ev_i), .trig_i (trig_i), .mrs_i (mrs_i),
  .seq_mode_i (seq_mode_i), .bad_cmd_i (bad_cmd_i), .dma_en_i (dma_en_i),
  .wr_en_i (wr_en_i), .wr_sel_i (wr_sel_i), .wr_data_i (wr_data_i),
  .fault_o (fault_o), .err_irq_o (err_irq_o), .mrs_dma_o (mrs_dma_o), .busy (busy)
);

// File: tb/test_ctu_fault_agg.sv
`timescale 1ns/1ps
module test_ctu_fault_agg;
  localparam int unsigned N = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ev_i = 0, mrs_i = 0, seq_mode_i = 0, bad_cmd_i = 0;
  logic [N-1:0] trig_i = '0, trig_en_i = '0, trig_irq_en_i = '0;
  logic mrs_irq_en_i = 0, err_irq_en_i = 0, dma_en_i = 0;
  logic wr_en_i = 0, wr_sel_i = 0;
  logic [N:0] wr_data_i = '0;
  logic [2:0] fault_o;
  logic err_irq_o, mrs_irq_o, mrs_dma_o;
  logic [N-1:0] trig_irq_o;
  int errs = 0, checks = 0;

  always #2.5 clk_i = ~clk_i;

  ctu_fault_agg #(.N_TRIG(N)) i_ctu_fault_agg (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic clear_all();
    wr_en_i = 1; wr_data_i = '1;
    wr_sel_i = 0; tick();
    wr_sel_i = 1; tick();
    wr_en_i = 0; wr_data_i = '0; wr_sel_i = 0;
  endtask

  task automatic flush_busy();
    trig_i = '1; tick(); trig_i = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    err_irq_en_i = 1; mrs_irq_en_i = 1; trig_irq_en_i = '1;
    #12 rst_ni = 1'b1; #0.5;
    // R11 reset state
    chk("R11", {fault_o, err_irq_o, trig_irq_o, mrs_irq_o, mrs_dma_o}, '0);
    tick();

    // R1/R2 sweep: mode x prior state (0 idle,1 busy,2 busy then trigger) x same-cycle trigger
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 3; p++)
        for (int t = 0; t < 2; t++) begin
          flush_busy(); clear_all();
          seq_mode_i = s[0];
          if (p >= 1) begin ev_i = 1; tick(); ev_i = 0; end
          if (p == 2) begin trig_i = 4'b0010; tick(); trig_i = '0; end
          ev_i = 1; trig_i = t[0] ? 4'b0100 : '0; tick(); ev_i = 0; trig_i = '0;
          chk("R2", fault_o[0], (s == 1 && p == 1 && t == 0));
          if (s == 1) begin
            // R1: event wins over trigger, so busy remains set
            clear_all(); ev_i = 1; tick(); ev_i = 0;
            chk("R1", fault_o[0], 1);
          end
          seq_mode_i = 0;
        end

    // R3 sweep over enable mask and fired set
    for (int e = 0; e < 16; e++)
      for (int f = 0; f < 16; f++) begin
        trig_en_i = e[3:0];
        mrs_i = 1; tick(); mrs_i = 0;
        flush_busy(); // fires all: re-open period below
        mrs_i = 1; tick(); mrs_i = 0;
        clear_all();
        trig_i = f[3:0]; tick(); trig_i = '0;
        mrs_i = 1; tick(); mrs_i = 0;
        chk("R3", fault_o[1], ((e & ~f & 15) != 0));
      end

    // R3 same-cycle trigger counts; R4 record cleared by reload
    trig_en_i = 4'b0001;
    mrs_i = 1; tick(); mrs_i = 0; clear_all();
    mrs_i = 1; trig_i = 4'b0001; tick(); mrs_i = 0; trig_i = '0;
    chk("R3", fault_o[1], 0);
    mrs_i = 1; tick(); mrs_i = 0;
    chk("R4", fault_o[1], 1);
    trig_en_i = '0; clear_all();

    // R5 / R7
    bad_cmd_i = 1; tick(); bad_cmd_i = 0;
    chk("R5", fault_o, 3'b100);
    chk("R7", err_irq_o, 1);
    err_irq_en_i = 0; #0.5;
    chk("R7", err_irq_o, 0);
    err_irq_en_i = 1;

    // R6: writing 0 keeps, writing 1 clears, set wins
    wr_en_i = 1; wr_sel_i = 0; wr_data_i = 5'b00011; tick(); wr_en_i = 0;
    chk("R6", fault_o, 3'b100);
    wr_en_i = 1; wr_data_i = 5'b00100; bad_cmd_i = 1; tick(); wr_en_i = 0; bad_cmd_i = 0;
    chk("R6", fault_o, 3'b100);
    wr_en_i = 1; wr_data_i = 5'b00100; wr_sel_i = 1; tick(); wr_en_i = 0; wr_sel_i = 0;
    chk("R6", fault_o, 3'b100);
    wr_en_i = 1; wr_data_i = 5'b00100; tick(); wr_en_i = 0;
    chk("R6", fault_o, 3'b000);
    chk("R7", err_irq_o, 0);

    // R8 per-trigger interrupt flags and enables
    for (int i = 0; i < N; i++)
      for (int m = 0; m < 2; m++) begin
        flush_busy(); clear_all();
        trig_irq_en_i = m[0] ? (4'b1 << i) : ~(4'b1 << i);
        trig_i = 4'b1 << i; tick(); trig_i = '0; tick();
        chk("R8", trig_irq_o, m[0] ? (4'b1 << i) : 4'b0);
        trig_irq_en_i = '1; #0.5;
        chk("R8", trig_irq_o, 4'b1 << i);
        wr_en_i = 1; wr_sel_i = 1; wr_data_i = 5'(1 << i); tick(); wr_en_i = 0;
        chk("R8", trig_irq_o, 0);
      end

    // R9 / R10
    clear_all(); trig_en_i = '0;
    mrs_irq_en_i = 0; dma_en_i = 0;
    mrs_i = 1; tick(); mrs_i = 0;
    chk("R9", mrs_irq_o, 0);
    chk("R10", mrs_dma_o, 0);
    mrs_irq_en_i = 1; #0.5;
    chk("R9", mrs_irq_o, 1);
    wr_en_i = 1; wr_sel_i = 1; wr_data_i = 5'b01111; tick(); wr_en_i = 0;
    chk("R9", mrs_irq_o, 1);
    wr_en_i = 1; wr_data_i = 5'b10000; tick(); wr_en_i = 0;
    chk("R9", mrs_irq_o, 0);
    dma_en_i = 1; mrs_i = 1; tick(); mrs_i = 0;
    chk("R10", mrs_dma_o, 1);
    tick();
    chk("R10", mrs_dma_o, 0);

    summary();
  end
endmodule